// File: doc/BRIEF.md
# Stepped Voice Gain Stage

This block scales a stream of signed 16-bit speech samples on their way to a playback converter. Two independent controls set the gain. A coarse volume attenuates in five steps of roughly 6 dB each, from 0 dB down to -24 dB. A fine trim calibrates the level between -6 dB and +6 dB in 1 dB steps. A mute control forces silence, and a bypass control hands samples through with no gain applied.

A three-register write port holds the settings. Samples enter and leave on valid/ready streaming ports. The block works on one sample at a time, under a small three-state controller.

A setting written to the registers is only staged. The staged settings are copied into the sample path at the moment a sample is accepted. The sample in flight therefore keeps the gain it entered with, so a change of level never splits a sample. The product is rounded to nearest and clamped to the signed 16-bit range.

The controller has three states:

- ST_IDLE waits for input, with `in_ready` high. Transition T_ACCEPT goes to ST_CALC when `in_valid` is high.
- ST_CALC computes the result during one cycle. Transition T_DONE always goes to ST_HOLD.
- ST_HOLD presents the result with `out_valid` high. Transition T_HANDOFF goes back to ST_IDLE when `out_ready` is high. Otherwise the controller stays in ST_HOLD.

Top module: `vgain_stage`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0. The settings are volume code 0, trim 0, unmuted and not bypassed, so a sample passes with unity gain.
- R2: A sample accepted at a clock edge gives `out_valid` high two edges later. `in_ready` stays low from the accepting edge until the result is taken, so at most one sample is in flight.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R4: Register writes use `cfg_addr`. Address 0 holds the volume code, read as unsigned. Address 1 holds the trim in dB, read as 8-bit two's complement. At address 2, bit 0 is mute and bit 1 is bypass. A write to address 3 changes nothing.
- R5: The coarse volume code v (0 to 4) arithmetically shifts the sample right by v bits, rounding toward minus infinity, before the trim is applied.
- R6: A trim of t dB uses the coefficient c = round(16384·10^(t/20)). The result is floor((s·c + 8192)/16384), where s is the shifted sample.
- R7: A result above 32767 becomes 32767, and a result below -32768 becomes -32768.
- R8: When mute is set, the output sample is 0, whatever the bypass setting is.
- R9: When bypass is set and mute is clear, the output sample equals the input sample.
- R10: A volume code above 4 is stored as 4. A trim above +6 is stored as +6, and a trim below -6 is stored as -6.
- R11: A sample uses the settings staged when it was accepted. A write made while a sample is in flight applies only from the next accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 16 | Input sample, signed |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream takes the sample |
| out_data | output | 16 | Output sample, signed |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 8-bit register data and a Q2.14 trim coefficient. At these widths, full-scale inputs of +32767 and -32768 with +6 dB trim drive the product beyond both clamp rails. Register bytes such as 200 and -128 exercise the clipping of out-of-range codes. The expected results come from the decibel formula itself, evaluated in real arithmetic, so an error in a coefficient entry is exposed. Holding `out_ready` low keeps a result parked in ST_HOLD long enough to write a new volume in mid-flight and observe that the parked sample keeps its old gain.

// File: rtl/vgain_pkg.sv
package vgain_pkg;

    localparam int VOL_LIM   = 4;
    localparam int TRIM_LIM  = 6;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 14;

    localparam logic [1:0] ADDR_VOL  = 2'd0;
    localparam logic [1:0] ADDR_TRIM = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_HOLD = 2'd2
    } vg_state_e;

    // trim is a 4-bit two's complement dB value in -6..+6
    typedef struct packed {
        logic [2:0] vol;
        logic [3:0] trim;
        logic       mute;
        logic       bypass;
    } vg_set_t;

    // Q2.14 value of 10^(t/20)
    function automatic logic [COEF_W-1:0] trim_coef(input logic [3:0] t);
        logic [COEF_W-1:0] c;
        case (t)
            4'd10:   c = 16'd8211;
            4'd11:   c = 16'd9213;
            4'd12:   c = 16'd10338;
            4'd13:   c = 16'd11599;
            4'd14:   c = 16'd13014;
            4'd15:   c = 16'd14602;
            4'd0:    c = 16'd16384;
            4'd1:    c = 16'd18383;
            4'd2:    c = 16'd20626;
            4'd3:    c = 16'd23143;
            4'd4:    c = 16'd25967;
            4'd5:    c = 16'd29135;
            4'd6:    c = 16'd32690;
            default: c = 16'd16384;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/vgain_regs.sv
module vgain_regs
    import vgain_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output vg_set_t          stg_set
);

    localparam logic [CFG_W-1:0]        VOL_MAX = CFG_W'(VOL_LIM);
    localparam logic signed [CFG_W-1:0] TRIM_HI = CFG_W'(TRIM_LIM);
    localparam logic signed [CFG_W-1:0] TRIM_LO = -TRIM_HI;

    logic signed [CFG_W-1:0] wr_signed;
    logic [2:0]              vol_clip;
    logic [3:0]              trim_clip;

    assign wr_signed = $signed(cfg_wdata);

    always_comb begin
        if (cfg_wdata > VOL_MAX) begin
            vol_clip = 3'(VOL_LIM);
        end else begin
            vol_clip = cfg_wdata[2:0];
        end
        if (wr_signed > TRIM_HI) begin
            trim_clip = 4'(TRIM_LIM);
        end else if (wr_signed < TRIM_LO) begin
            trim_clip = 4'(-TRIM_LIM);
        end else begin
            trim_clip = wr_signed[3:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_set <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                ADDR_VOL:  stg_set.vol  <= vol_clip;
                ADDR_TRIM: stg_set.trim <= trim_clip;
                ADDR_CTRL: begin
                    stg_set.mute   <= cfg_wdata[0];
                    stg_set.bypass <= cfg_wdata[1];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/vgain_ctrl.sv
module vgain_ctrl
    import vgain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load_in,
    output logic load_out
);

    vg_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_ACCEPT, T_DONE, T_HANDOFF
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_CALC;
            ST_CALC:                state_d = ST_HOLD;
            ST_HOLD: if (out_ready) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load_in   = 1'b0;
        load_out  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                load_in  = in_valid;
            end
            ST_CALC: load_out  = 1'b1;
            ST_HOLD: out_valid = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/vgain_math.sv
module vgain_math
    import vgain_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_in,
    input  logic              load_out,
    input  logic [DATA_W-1:0] in_data,
    input  vg_set_t           stg_set,
    output logic [DATA_W-1:0] out_data,
    output vg_set_t           act_set,
    output logic [DATA_W-1:0] act_x
);

    localparam int PW = DATA_W + COEF_W + 2;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (COEF_FRAC - 1);
    localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (DATA_W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic signed [DATA_W-1:0] x_q;
    logic        [DATA_W-1:0] y_q;
    logic signed [DATA_W-1:0] shifted;
    logic        [COEF_W-1:0] coef;
    logic signed [PW-1:0]     sx, cx, prod, scaled;
    logic        [DATA_W-1:0] sat, y_c;

    // sample and its settings are captured together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q     <= '0;
            act_set <= '0;
        end else if (load_in) begin
            x_q     <= $signed(in_data);
            act_set <= stg_set;
        end
    end

    always_comb begin
        shifted = x_q >>> act_set.vol;
        coef    = trim_coef(act_set.trim);
        sx      = PW'(shifted);
        cx      = PW'($signed({1'b0, coef}));
        prod    = sx * cx;
        scaled  = (prod + HALF) >>> COEF_FRAC;
        if (scaled > MAXV) begin
            sat = MAXV[DATA_W-1:0];
        end else if (scaled < MINV) begin
            sat = MINV[DATA_W-1:0];
        end else begin
            sat = scaled[DATA_W-1:0];
        end
        if (act_set.mute) begin
            y_c = '0;
        end else if (act_set.bypass) begin
            y_c = x_q;
        end else begin
            y_c = sat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q <= '0;
        end else if (load_out) begin
            y_q <= y_c;
        end
    end

    assign out_data = y_q;
    assign act_x    = x_q;

endmodule

// File: rtl/vgain_stage.sv
module vgain_stage
    import vgain_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CFG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    vg_set_t           stg_set;
    vg_set_t           act_set;
    logic [DATA_W-1:0] act_x;
    logic              load_in;
    logic              load_out;

    vgain_regs #(.CFG_W(CFG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .stg_set   (stg_set)
    );

    vgain_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load_in   (load_in),
        .load_out  (load_out)
    );

    vgain_math #(.DATA_W(DATA_W)) u_math (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_in  (load_in),
        .load_out (load_out),
        .in_data  (in_data),
        .stg_set  (stg_set),
        .out_data (out_data),
        .act_set  (act_set),
        .act_x    (act_x)
    );

endmodule

// File: rtl/vgain_chk.sv
module vgain_chk
    import vgain_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input vg_set_t           stg_set,
    input vg_set_t           act_set,
    input logic [DATA_W-1:0] act_x
);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !out_valid ##1 out_valid);

    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_mute_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && act_set.mute) |-> (out_data == '0));

    p_bypass_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && act_set.bypass && !act_set.mute) |-> (out_data == act_x));

    p_vol_clip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stg_set.vol <= 3'(VOL_LIM));

    p_trim_clip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(stg_set.trim) <= 4'sd6) && ($signed(stg_set.trim) >= -4'sd6));

    p_settings_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(act_set));

endmodule

bind vgain_stage vgain_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .stg_set   (stg_set),
    .act_set   (act_set),
    .act_x     (act_x)
);

// File: tb/test_vgain_stage.sv
module test_vgain_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    int m_vol = 0, m_trim = 0, m_mute = 0, m_byp = 0;
    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    vgain_stage i_vgain_stage (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_of(input int x);
        int  sh, c;
        longint p, y;
        if (m_mute != 0) return 0;
        if (m_byp != 0) return x;
        sh = x >>> m_vol;
        c  = $rtoi(16384.0 * (10.0 ** (m_trim / 20.0)) + 0.5);
        p  = longint'(sh) * longint'(c);
        y  = (p + 64'sd8192) >>> 14;
        if (y > 32767) y = 32767;
        if (y < -32768) y = -32768;
        return int'(y);
    endfunction

    task automatic wr(input int a, input int d);
        logic [7:0] b;
        int s;
        b = d[7:0];
        s = int'($signed(b));
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a[1:0]; cfg_wdata = b;
        case (a)
            0: m_vol  = (int'(b) > 4) ? 4 : int'(b);
            1: m_trim = (s > 6) ? 6 : ((s < -6) ? -6 : s);
            2: begin m_mute = int'(b[0]); m_byp = int'(b[1]); end
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input int x, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_data = x[15:0];
        while (!in_ready) @(negedge clk);
        exp_q.push_back(exp_of(x));
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", int'($signed(out_data)), 0);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(int'($signed(out_data)) == e, t, int'($signed(out_data)), e);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL R2: watchdog expired, actual %0d expected %0d", cyc, 100000);
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(out_data == 16'd0, "R1", int'(out_data), 0);
        send(1000, "R1");
        // R2 latency and single occupancy
        chk(out_valid == 1'b0, "R2", int'(out_valid), 0);
        chk(in_ready == 1'b0, "R2", int'(in_ready), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R2", int'(out_valid), 1);
        drain();
        // R5 coarse volume
        for (int v = 0; v <= 4; v++) begin
            wr(0, v);
            send(12345, "R5");
            send(-12345, "R5");
            send(-1, "R5");
        end
        drain();
        // R6 fine trim
        wr(0, 0);
        for (int t = -6; t <= 6; t++) begin
            wr(1, t);
            send(10000, "R6");
            send(-7777, "R6");
        end
        wr(0, 2); wr(1, 3);
        send(20001, "R6");
        drain();
        // R7 saturation
        wr(0, 0); wr(1, 6);
        send(32767, "R7");
        send(-32768, "R7");
        send(20000, "R7");
        drain();
        // R10 clipping of out-of-range codes
        wr(0, 200);
        send(30000, "R10");
        wr(0, 0); wr(1, -128);
        send(30000, "R10");
        wr(1, 100);
        send(-30000, "R10");
        drain();
        // R4 address 3 has no effect
        wr(3, 255);
        send(-30000, "R4");
        send(12000, "R4");
        drain();
        // R8 mute, also over bypass
        wr(2, 1);
        send(32767, "R8");
        wr(2, 3);
        send(-32768, "R8");
        drain();
        // R9 bypass
        wr(0, 4); wr(1, 6); wr(2, 2);
        send(-32768, "R9");
        send(1234, "R9");
        wr(2, 0);
        drain();
        // R3, R11 stall with a write while the sample is in flight
        wr(0, 0); wr(1, 0);
        @(posedge clk); #2 out_ready = 1'b0;
        begin
            int e;
            e = exp_of(16000);
            send(16000, "R11");
            wr(0, 3);
            repeat (2) @(negedge clk);
            chk(out_valid == 1'b1, "R3", int'(out_valid), 1);
            chk(int'($signed(out_data)) == e, "R3", int'($signed(out_data)), e);
            chk(in_ready == 1'b0, "R2", int'(in_ready), 0);
            @(negedge clk);
            chk(int'($signed(out_data)) == e, "R3", int'($signed(out_data)), e);
        end
        @(posedge clk); #2 out_ready = 1'b1;
        drain();
        send(16000, "R11");
        drain();
        repeat (4) @(negedge clk);
        report();
        $finish;
    end

endmodule